// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block is the register target at the end of a three-wire serial link that drives a display controller. Clock, chip select and one data line run between master and target. The data line carries traffic both ways. Because the pad driver is not part of this block, the shared line appears as three signals: a sampled input, an output value and an output enable.

Each frame begins with a header. The header holds a 6-bit register address and then a direction flag. For a write, one padding bit follows the header, then eight data bits from the master. For a read, the header is only seven bits long. The eighth clock is a turnaround in which neither side drives the line. The target then drives eight data bits.

Behind the link sit four registers:
- a scratch register for checking the link;
- a fixed identity byte;
- a resolution code;
- a power/control byte.

The power/control byte decides whether the display logic takes its resolution and standby state from the registers or from strap inputs.

Top module: `spi3_reg_target`

## Requirements
- R1: On each rising `sclk` edge while `cs_n` is low, the target samples `sdio_in`. Frame bits 0 to 5 are the register address, MSB first. Bit 6 is the direction flag (1 = read, 0 = write). In a write, bit 7 is padding and bits 8 to 15 are the data byte, MSB first. The write takes effect at the 16th rising edge.
- R2: In a read frame, `sdio_oe` stays low through the first 8 rising edges, which include the turnaround clock. From the falling edge after the 8th rising edge, the target drives the 8 data bits MSB first, one per falling edge, with `sdio_oe` high. It releases the line after the 16th rising edge. In a write frame, `sdio_oe` never goes high.
- R3: Address 0x00 is an 8-bit scratch register that can be read and written. Its reset value is 0x00.
- R4: Address 0x01 is read-only. It returns {CHIP_ID, CHIP_REV} in the upper and lower nibbles, which is 0x13 with the default parameters. Writes to it are ignored.
- R5: Address 0x02 stores a resolution code in bits 2:0. Its other bits read as 0. Its reset value is 3'b111.
- R6: Address 0x03 stores bit 0 (1 = active, 0 = standby) and bit 7 (1 = software control, 0 = strap control). Its other bits read as 0. Its reset value is 0x00.
- R7: Under software control, one clock after the register changes, `res_code` equals the bits 2:0 of address 0x02 and `standby` equals the inverse of bit 0 of address 0x03. The straps then have no effect.
- R8: Under strap control, `res_code` follows `strap_res` and `standby` follows `strap_standby`, each one clock later.
- R9: Reads of addresses 0x04 to 0x3F return 0x00. Writes to those addresses change no register.
- R10: Taking `cs_n` high at any point ends the frame. A partial write is dropped, `sdio_oe` falls at the next falling edge, and the next frame starts again at header bit 0.
- R11: While `rst_n` is low at a rising edge, the registers return to their reset values. During reset, `res_code` is 3'b111, `standby` is 1 and `sdio_oe` is 0. Frames sent during reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state is timed by it |
| rst_n | input | 1 | Active-low reset, sampled on the rising edge |
| cs_n | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Value sampled from the shared data line |
| sdio_out | output | 1 | Value to drive on the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| strap_res | input | 3 | Resolution code from board straps |
| strap_standby | input | 1 | Standby request from board straps |
| res_code | output | 3 | Resolution code for the display logic |
| standby | output | 1 | Standby state for the display logic (1 = standby) |

## Verification
The hardest cases to reach from the ports are frames that stop part-way. One is a write cut off after its data phase has begun; another is a read cut off while the target drives the line. A third is a frame sent while reset is held, which must leave no trace.

The bench frame task takes a bit count as well as the address and data. Any frame can therefore be cut at an exact bit position. A full read that follows shows whether the partial frame changed anything. The drive enable is watched around the cut to confirm the line is released.

Bit order is checked with addresses and data whose mirror images decode differently. Examples are address 0x20 against 0x01, and data 0x80.

// File: rtl/spi3_regs_pkg.sv
package spi3_regs_pkg;

  // Frame geometry (defaults; modules take their own parameters)
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_RES_W  = 3;

  // Register addresses decoded by the register bank
  localparam int A_SCRATCH = 0;
  localparam int A_IDENT   = 1;
  localparam int A_RES     = 2;
  localparam int A_PWR     = 3;

  // Bit positions inside the power/control byte
  localparam int PWR_ON_BIT = 0;

  function automatic int sw_ctrl_bit(input int data_w);
    return data_w - 1;
  endfunction

endpackage

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_regs_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int HDR_W   = ADDR_W + 1,
  localparam int DATA_LO = HDR_W + 1,
  localparam int FRAME_W = DATA_LO + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdio_in,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              rd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_en,
  output logic [DATA_W-1:0] wdata
);

  localparam logic [CNT_W-1:0] C_DIR  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_DLO  = CNT_W'(DATA_LO);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME_W);

  logic [DATA_W-2:0] shreg_q;

  // Bit counter, header capture and write data shift
  always_ff @(posedge sclk) begin
    if (!rst_n || cs_n) begin
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      shreg_q <= '0;
    end else if (cnt_q != C_END) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q < C_DIR)
        addr_q <= {addr_q[ADDR_W-2:0], sdio_in};
      if (cnt_q == C_DIR)
        rd_q <= sdio_in;
      if (cnt_q >= C_DLO)
        shreg_q <= {shreg_q[DATA_W-3:0], sdio_in};
    end
  end

  // Commit strobe on the last data bit of a write frame
  assign wr_en = rst_n && !cs_n && !rd_q && (cnt_q == C_LAST);
  assign wdata = {shreg_q, sdio_in};

  // R10
  abort_clears_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |=> (cnt_q == '0) && !rd_q);

  // R1
  header_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && cnt_q > C_DIR) |=> $stable(addr_q));

endmodule

// File: rtl/spi3_regbank.sv
module spi3_regbank
  import spi3_regs_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int RES_W  = DEF_RES_W,
  localparam int NIB_W = DATA_W / 2,
  parameter logic [NIB_W-1:0] CHIP_ID  = NIB_W'(1),
  parameter logic [NIB_W-1:0] CHIP_REV = NIB_W'(3),
  parameter logic [RES_W-1:0] RES_RST  = '1,
  localparam int SW_BIT = sw_ctrl_bit(DATA_W)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [RES_W-1:0]  strap_res,
  input  logic              strap_standby,
  output logic [RES_W-1:0]  res_code_q,
  output logic              standby_q
);

  localparam logic [ADDR_W-1:0] AD_SCR = ADDR_W'(A_SCRATCH);
  localparam logic [ADDR_W-1:0] AD_ID  = ADDR_W'(A_IDENT);
  localparam logic [ADDR_W-1:0] AD_RES = ADDR_W'(A_RES);
  localparam logic [ADDR_W-1:0] AD_PWR = ADDR_W'(A_PWR);

  logic [DATA_W-1:0] scratch_q;
  logic [RES_W-1:0]  res_q;
  logic              pwr_on_q;
  logic              sw_ctrl_q;

  // Register writes
  always_ff @(posedge sclk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      res_q     <= RES_RST;
      pwr_on_q  <= 1'b0;
      sw_ctrl_q <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        AD_SCR: scratch_q <= wdata;
        AD_RES: res_q     <= wdata[RES_W-1:0];
        AD_PWR: begin
          pwr_on_q  <= wdata[PWR_ON_BIT];
          sw_ctrl_q <= wdata[SW_BIT];
        end
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      AD_SCR: rdata = scratch_q;
      AD_ID:  rdata = {CHIP_ID, CHIP_REV};
      AD_RES: rdata[RES_W-1:0] = res_q;
      AD_PWR: begin
        rdata[PWR_ON_BIT] = pwr_on_q;
        rdata[SW_BIT]     = sw_ctrl_q;
      end
      default: rdata = '0;
    endcase
  end

  // Control source select, registered toward the display logic
  always_ff @(posedge sclk) begin
    if (!rst_n) begin
      res_code_q <= RES_RST;
      standby_q  <= 1'b1;
    end else if (sw_ctrl_q) begin
      res_code_q <= res_q;
      standby_q  <= !pwr_on_q;
    end else begin
      res_code_q <= strap_res;
      standby_q  <= strap_standby;
    end
  end

  // R3
  scratch_commit_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (wr_en && addr == AD_SCR) |=> scratch_q == $past(wdata));

  // R9
  ignore_unmapped_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (wr_en && addr > AD_PWR) |=>
      $stable(scratch_q) && $stable(res_q) && $stable(pwr_on_q) && $stable(sw_ctrl_q));

  // R8
  strap_follow_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !sw_ctrl_q |=> (res_code_q == $past(strap_res)) && (standby_q == $past(strap_standby)));

  // R7
  sw_follow_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    sw_ctrl_q |=> (standby_q == !$past(pwr_on_q)) && (res_code_q == $past(res_q)));

endmodule

// File: rtl/spi3_txdrv.sv
module spi3_txdrv
  import spi3_regs_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int HDR_W   = ADDR_W + 1,
  localparam int DATA_LO = HDR_W + 1,
  localparam int FRAME_W = DATA_LO + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              is_rd,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_bit,
  output logic              out_en
);

  localparam logic [CNT_W-1:0] C_DLO = CNT_W'(DATA_LO);
  localparam logic [CNT_W-1:0] C_END = CNT_W'(FRAME_W);

  logic [DATA_W-2:0] sh_q;

  // Data leaves on the falling edge so the master samples it on the rising edge
  always_ff @(negedge sclk) begin
    if (!rst_n || cs_n) begin
      out_en  <= 1'b0;
      out_bit <= 1'b0;
      sh_q    <= '0;
    end else if (is_rd && cnt == C_DLO) begin
      out_en  <= 1'b1;
      out_bit <= rdata[DATA_W-1];
      sh_q    <= rdata[DATA_W-2:0];
    end else if (is_rd && cnt > C_DLO && cnt < C_END) begin
      out_en  <= 1'b1;
      out_bit <= sh_q[DATA_W-2];
      sh_q    <= {sh_q[DATA_W-3:0], 1'b0};
    end else begin
      out_en  <= 1'b0;
      out_bit <= 1'b0;
    end
  end

  // R2
  turnaround_hiz_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (cnt < C_DLO) |-> !out_en);

  // R2
  no_drive_on_write_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    out_en |-> is_rd);

endmodule

// File: rtl/spi3_reg_target.sv
module spi3_reg_target
  import spi3_regs_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int RES_W  = DEF_RES_W,
  localparam int NIB_W = DATA_W / 2,
  parameter logic [NIB_W-1:0] CHIP_ID  = NIB_W'(1),
  parameter logic [NIB_W-1:0] CHIP_REV = NIB_W'(3),
  parameter logic [RES_W-1:0] RES_RST  = '1,
  localparam int CNT_W = $clog2(ADDR_W + 2 + DATA_W + 1)
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sdio_in,
  output logic             sdio_out,
  output logic             sdio_oe,
  input  logic [RES_W-1:0] strap_res,
  input  logic             strap_standby,
  output logic [RES_W-1:0] res_code,
  output logic             standby
);

  logic [CNT_W-1:0]  cnt;
  logic              is_rd;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  spi3_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sdio_in (sdio_in),
    .cnt_q   (cnt),
    .rd_q    (is_rd),
    .addr_q  (addr),
    .wr_en   (wr_en),
    .wdata   (wdata)
  );

  spi3_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W),
    .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .RES_RST(RES_RST)
  ) u_regs (
    .sclk          (sclk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wr_en         (wr_en),
    .wdata         (wdata),
    .rdata         (rdata),
    .strap_res     (strap_res),
    .strap_standby (strap_standby),
    .res_code_q    (res_code),
    .standby_q     (standby)
  );

  spi3_txdrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cnt     (cnt),
    .is_rd   (is_rd),
    .rdata   (rdata),
    .out_bit (sdio_out),
    .out_en  (sdio_oe)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge sclk)
    $past(!rst_n) && !rst_n |-> !sdio_oe && standby && (res_code == RES_RST));

endmodule

// File: tb/tb_spi3_reg_target.sv
module tb_spi3_reg_target;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sdio_in = 1'b0;
  logic       sdio_out;
  logic       sdio_oe;
  logic [2:0] strap_res = 3'd4;
  logic       strap_standby = 1'b0;
  logic [2:0] res_code;
  logic       standby;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi3_reg_target dut (
    .sclk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .strap_res(strap_res), .strap_standby(strap_standby),
    .res_code(res_code), .standby(standby)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One frame, optionally cut after nbits rising edges
  task automatic xfer(input logic rw, input logic [5:0] a, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rd, output logic oe_bad);
    rd = '0;
    oe_bad = 1'b0;
    @(negedge clk); #2;
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i < 6)       sdio_in = a[5-i];
      else if (i == 6) sdio_in = rw;
      else if (i == 7) sdio_in = 1'b0;
      else             sdio_in = rw ? 1'b0 : wd[15-i];
      @(posedge clk); #1;
      if (i <= 7) begin
        if (sdio_oe) oe_bad = 1'b1;
      end else if (rw) begin
        if (!sdio_oe) oe_bad = 1'b1;
        rd[15-i] = sdio_out;
      end else if (sdio_oe) oe_bad = 1'b1;
      @(negedge clk); #2;
    end
    cs_n = 1'b1;
    sdio_in = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    if (sdio_oe) oe_bad = 1'b1;
  endtask

  // {rw, addr, wdata, expected read, requirement}
  localparam int NV = 18;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 6'h00, 8'h55, 8'h00, 4'd3},  // R3 write scratch
    {1'b1, 6'h00, 8'h00, 8'h55, 4'd3},  // R3 read back
    {1'b0, 6'h00, 8'h80, 8'h00, 4'd1},  // R1 MSB-first data
    {1'b1, 6'h00, 8'h00, 8'h80, 4'd1},
    {1'b1, 6'h20, 8'h00, 8'h00, 4'd1},  // R1 MSB-first address
    {1'b1, 6'h01, 8'h00, 8'h13, 4'd4},  // R4 identity
    {1'b0, 6'h01, 8'hFF, 8'h00, 4'd4},
    {1'b1, 6'h01, 8'h00, 8'h13, 4'd4},
    {1'b0, 6'h02, 8'hFD, 8'h00, 4'd5},  // R5 only bits 2:0 kept
    {1'b1, 6'h02, 8'h00, 8'h05, 4'd5},
    {1'b0, 6'h03, 8'hFF, 8'h00, 4'd6},  // R6 only bits 7 and 0 kept
    {1'b1, 6'h03, 8'h00, 8'h81, 4'd6},
    {1'b0, 6'h05, 8'h77, 8'h00, 4'd9},  // R9 unmapped write
    {1'b1, 6'h05, 8'h00, 8'h00, 4'd9},
    {1'b1, 6'h3F, 8'h00, 8'h00, 4'd9},
    {1'b1, 6'h00, 8'h00, 8'h80, 4'd9},  // R9 scratch untouched
    {1'b0, 6'h03, 8'h00, 8'h00, 4'd6},
    {1'b1, 6'h03, 8'h00, 8'h00, 4'd6}
  };

  initial begin
    logic [7:0] rd;
    logic       oe_bad;

    // R11 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R11 standby in reset", {31'd0, standby}, 32'd1);
    chk("R11 res_code in reset", {29'd0, res_code}, 32'd7);
    chk("R11 oe in reset", {31'd0, sdio_oe}, 32'd0);
    @(negedge clk); #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 strap res", {29'd0, res_code}, 32'd4);
    chk("R8 strap standby", {31'd0, standby}, 32'd0);
    xfer(1'b1, 6'h02, 8'h00, 16, rd, oe_bad);
    chk("R5 reset value", {24'd0, rd}, 32'h07);
    xfer(1'b1, 6'h03, 8'h00, 16, rd, oe_bad);
    chk("R6 reset value", {24'd0, rd}, 32'h00);
    xfer(1'b1, 6'h00, 8'h00, 16, rd, oe_bad);
    chk("R3 reset value", {24'd0, rd}, 32'h00);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      xfer(VEC[k][26], VEC[k][25:20], VEC[k][19:12], 16, rd, oe_bad);
      chk($sformatf("R2 oe pattern (row %0d)", k), {31'd0, oe_bad}, 32'd0);
      if (VEC[k][26])
        chk($sformatf("R%0d read row %0d", VEC[k][3:0], k), {24'd0, rd}, {24'd0, VEC[k][11:4]});
    end

    // R7 software control
    xfer(1'b0, 6'h02, 8'h03, 16, rd, oe_bad);
    xfer(1'b0, 6'h03, 8'h81, 16, rd, oe_bad);
    chk("R7 res from register", {29'd0, res_code}, 32'd3);
    chk("R7 active", {31'd0, standby}, 32'd0);
    @(negedge clk); #2;
    strap_res = 3'd6;
    strap_standby = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 straps ignored res", {29'd0, res_code}, 32'd3);
    chk("R7 straps ignored standby", {31'd0, standby}, 32'd0);
    xfer(1'b0, 6'h03, 8'h80, 16, rd, oe_bad);
    chk("R7 standby from register", {31'd0, standby}, 32'd1);

    // R8 back to strap control
    xfer(1'b0, 6'h03, 8'h01, 16, rd, oe_bad);
    chk("R8 strap res again", {29'd0, res_code}, 32'd6);
    chk("R8 strap standby again", {31'd0, standby}, 32'd1);

    // R10 aborted write and aborted read
    xfer(1'b0, 6'h00, 8'h5A, 16, rd, oe_bad);
    xfer(1'b0, 6'h00, 8'hC3, 12, rd, oe_bad);
    xfer(1'b1, 6'h00, 8'h00, 16, rd, oe_bad);
    chk("R10 partial write dropped", {24'd0, rd}, 32'h5A);
    xfer(1'b0, 6'h00, 8'h00, 3, rd, oe_bad);
    xfer(1'b1, 6'h01, 8'h00, 16, rd, oe_bad);
    chk("R10 restart after header abort", {24'd0, rd}, 32'h13);
    xfer(1'b1, 6'h01, 8'h00, 11, rd, oe_bad);
    chk("R10 line released after read abort", {31'd0, oe_bad}, 32'd0);

    // R11 reset clears and blocks frames
    @(negedge clk); #2;
    rst_n = 1'b0;
    xfer(1'b0, 6'h00, 8'h99, 16, rd, oe_bad);
    chk("R11 no drive during reset", {31'd0, oe_bad}, 32'd0);
    @(negedge clk); #2;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    xfer(1'b1, 6'h00, 8'h00, 16, rd, oe_bad);
    chk("R11 scratch cleared", {24'd0, rd}, 32'h00);
    xfer(1'b1, 6'h02, 8'h00, 16, rd, oe_bad);
    chk("R11 res cleared", {24'd0, rd}, 32'h07);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule